// File: doc/BRIEF.md
# 64-bit Bit-Rotate Execute Unit

This block sits in the execute stage of a 64-bit RISC-V core and handles the rotate instructions of the bit-manipulation extension. It looks at the 32-bit instruction word and recognises six rotate forms. Three work on the full 64-bit register: rotate right by a register, rotate left by a register, and rotate right by an immediate. Three are word forms: rotate right by a register, rotate left by a register, and rotate right by an immediate. For any recognised form it rotates the first source operand and returns the result within the same cycle. The block has no registers.

The word forms cut the operand down to its low 32 bits and rotate it within 32 bits. The 32-bit result is then sign-extended to 64 bits. No encoding exists for an immediate rotate left. When the extension is switched off, a rotate produces no result and raises a fault flag that the pipeline turns into an illegal-instruction trap. The result bus reads zero whenever the block does not claim the instruction.

Top module: `rot_unit`

## Requirements
- R1: Register rotate right: opcode 0110011, funct3 101, bits 31..25 = 0110000. The result is rs1 rotated right by rs2[5:0], and hit = 1.
- R2: Register rotate left: opcode 0110011, funct3 001, bits 31..25 = 0110000. The result is rs1 rotated left by rs2[5:0], and hit = 1.
- R3: Immediate rotate right: opcode 0010011, funct3 101, bits 31..26 = 011000. The amount is bits 25..20 of the instruction, and the rs2 operand has no effect.
- R4: Word register rotates: opcode 0111011, bits 31..25 = 0110000, funct3 101 for right and 001 for left. Only rs1[31:0] is rotated, by rs2[4:0]. The result is that 32-bit value sign-extended from its bit 31.
- R5: Word immediate rotate right: opcode 0011011, bits 31..25 = 0110000, funct3 101. rs1[31:0] is rotated right by bits 24..20 of the instruction, and the result is sign-extended.
- R6: funct3 001 under opcode 0010011 or 0011011 is never decoded as a rotate, even when the upper bits match the rotate pattern. For such words hit = 0, illegal = 0 and the result is 0.
- R7: A rotate decoded while extEnable = 0 gives illegal = 1, hit = 0 and result = 0. hit and illegal are never both 1.
- R8: Amount bits above bit 5 (64-bit forms) or above bit 4 (word forms) have no effect on the result.
- R9: A rotate amount of zero returns rs1 unchanged for the 64-bit forms. For the word forms it returns rs1[31:0] sign-extended.
- R10: Rotate left by n equals rotate right by (W - n) mod W, where W is 64 or 32.
- R11: Any encoding that is not a rotate gives hit = 0, illegal = 0 and result = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word under execution |
| rs1Val | input | 64 | First source operand (value rotated) |
| rs2Val | input | 64 | Second source operand (register rotate amount) |
| extEnable | input | 1 | Bit-manipulation extension enabled |
| result | output | 64 | Rotated value, zero when hit is low |
| hit | output | 1 | Instruction is a rotate and executed |
| illegal | output | 1 | Rotate decoded while the extension is disabled |

## Verification
Decoding and the enable gate act in the same cycle. A single instruction word can therefore be a valid rotate and a trap at once. The bench presents every rotate encoding twice, once with the extension enabled and once with it disabled, and keeps the operands identical between the two. It judges that exactly one of hit and illegal rises and that the result collapses to zero on the trap. It also places the word truncation and the sign extension in the same operation by choosing operands whose bit 31 is set only after the rotate. Rotate-left results are compared against rotate-right results with the complementary amount.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG_W  = 7'b0111011;
  localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
  localparam logic [6:0] F7_ROTATE  = 7'b0110000;
  localparam logic [2:0] F3_RIGHT   = 3'b101;
  localparam logic [2:0] F3_LEFT    = 3'b001;

  typedef struct packed {
    logic doRot;   // rotate recognised and permitted
    logic wordOp;  // 32-bit form with sign extension
    logic goLeft;  // direction
    logic useImm;  // amount from the instruction
  } rotCtrl_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [31:0]    instr,
  input  logic           extEnable,
  output rotCtrl_t       ctrl,
  output logic [SHW-1:0] immAmt,
  output logic           illegal
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic       isRot;
  logic       wordOp;
  logic       goLeft;
  logic       useImm;
  logic       unusedBits;

  assign opcode     = instr[6:0];
  assign funct3     = instr[14:12];
  assign funct7     = instr[31:25];
  assign unusedBits = ^{instr[19:15], instr[11:7]};
  assign immAmt     = instr[20 +: SHW];

  always_comb begin
    isRot  = 1'b0;
    wordOp = 1'b0;
    goLeft = 1'b0;
    useImm = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        if (funct7 == F7_ROTATE && (funct3 == F3_RIGHT || funct3 == F3_LEFT)) begin
          isRot  = 1'b1;
          goLeft = (funct3 == F3_LEFT);
        end
      end
      OPC_IMM: begin
        if (funct7[6:1] == F7_ROTATE[6:1] && funct3 == F3_RIGHT) begin
          isRot  = 1'b1;
          useImm = 1'b1;
        end
      end
      OPC_REG_W: begin
        if (funct7 == F7_ROTATE && (funct3 == F3_RIGHT || funct3 == F3_LEFT)) begin
          isRot  = 1'b1;
          wordOp = 1'b1;
          goLeft = (funct3 == F3_LEFT);
        end
      end
      OPC_IMM_W: begin
        if (funct7 == F7_ROTATE && funct3 == F3_RIGHT) begin
          isRot  = 1'b1;
          wordOp = 1'b1;
          useImm = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign ctrl.doRot  = isRot & extEnable;
  assign ctrl.wordOp = wordOp;
  assign ctrl.goLeft = goLeft;
  assign ctrl.useImm = useImm;
  assign illegal     = isRot & ~extEnable;
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int W = 64,
  localparam int S = $clog2(W)
) (
  input  logic [W-1:0] din,
  input  logic [S-1:0] amt,
  input  logic         goLeft,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [S+1];
  assign stage[0] = din;

  for (genvar g = 0; g < S; g++) begin : g_stage
    localparam int K = 1 << g;
    logic [W-1:0] leftVal;
    logic [W-1:0] rightVal;
    assign leftVal  = {stage[g][W-1-K:0], stage[g][W-1:W-K]};
    assign rightVal = {stage[g][K-1:0], stage[g][W-1:K]};
    assign stage[g+1] = amt[g] ? (goLeft ? leftVal : rightVal) : stage[g];
  end

  assign dout = stage[S];
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int WLEN = XLEN / 2,
  localparam int SHW  = $clog2(XLEN),
  localparam int WSHW = $clog2(WLEN)
) (
  input  rotCtrl_t       ctrl,
  input  logic [SHW-1:0] immAmt,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  output logic [XLEN-1:0] result
);
  logic [SHW-1:0]  amtSel;
  logic [XLEN-1:0] wideOut;
  logic [WLEN-1:0] narrowOut;
  logic            unusedHigh;

  assign unusedHigh = ^rs2Val[XLEN-1:SHW];
  assign amtSel = ctrl.useImm ? immAmt : rs2Val[SHW-1:0];

  rot_barrel #(.W(XLEN)) u_wide (
    .din(rs1Val), .amt(amtSel), .goLeft(ctrl.goLeft), .dout(wideOut)
  );

  rot_barrel #(.W(WLEN)) u_narrow (
    .din(rs1Val[WLEN-1:0]), .amt(amtSel[WSHW-1:0]), .goLeft(ctrl.goLeft),
    .dout(narrowOut)
  );

  always_comb begin
    if (!ctrl.doRot)      result = '0;
    else if (ctrl.wordOp) result = {{(XLEN-WLEN){narrowOut[WLEN-1]}}, narrowOut};
    else                  result = wideOut;
  end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic            extEnable,
  output logic [XLEN-1:0] result,
  output logic            hit,
  output logic            illegal
);
  rotCtrl_t       ctrl;
  logic [SHW-1:0] immAmt;

  rot_decode #(.XLEN(XLEN)) u_decode (
    .instr(instr), .extEnable(extEnable), .ctrl(ctrl), .immAmt(immAmt),
    .illegal(illegal)
  );

  rot_datapath #(.XLEN(XLEN)) u_datapath (
    .ctrl(ctrl), .immAmt(immAmt), .rs1Val(rs1Val), .rs2Val(rs2Val),
    .result(result)
  );

  assign hit = ctrl.doRot;
endmodule

// File: rtl/rot_unit_checker.sv
module rot_unit_checker #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs1Val,
  input logic [XLEN-1:0] rs2Val,
  input logic            extEnable,
  input logic [XLEN-1:0] result,
  input logic            hit,
  input logic            illegal
);
  logic known;
  logic [6:0] op;
  assign known = !$isunknown({instr, rs1Val, rs2Val, extEnable, result, hit, illegal});
  assign op = instr[6:0];

  function automatic logic [XLEN-1:0] refRotr(input logic [XLEN-1:0] x, input int n);
    logic [XLEN-1:0] y;
    y = x;
    for (int i = 0; i < n; i++) y = {y[0], y[XLEN-1:1]};
    return y;
  endfunction

  always_comb begin
    if (known) begin
      p_hit_excl_r7: assert (!(hit && illegal));
      p_disabled_r7: assert (extEnable || !hit);
      p_idle_zero_r11: assert (hit || result == '0);
      p_no_imm_left_r6: assert (!((op == 7'b0010011 || op == 7'b0011011) &&
                                  instr[14:12] == 3'b001) || (!hit && !illegal));
      p_word_sext_r4: assert (!(hit && (op == 7'b0111011 || op == 7'b0011011)) ||
                              result[XLEN-1:XLEN/2] == {(XLEN/2){result[XLEN/2-1]}});
      p_imm_ror_r3: assert (!(hit && op == 7'b0010011) ||
                            result == refRotr(rs1Val, int'(instr[25:20])));
      p_zero_amt_r9: assert (!(hit && op == 7'b0110011 && rs2Val[5:0] == 6'd0) ||
                             result == rs1Val);
    end
  end
endmodule

bind rot_unit rot_unit_checker #(.XLEN(XLEN)) u_chk (
  .instr(instr), .rs1Val(rs1Val), .rs2Val(rs2Val), .extEnable(extEnable),
  .result(result), .hit(hit), .illegal(illegal)
);

// File: tb/rot_unit_bench.sv
module rot_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs1Val = '0;
  logic [63:0] rs2Val = '0;
  logic        extEnable = 1'b0;
  logic [63:0] result;
  logic        hit;
  logic        illegal;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rot_unit u_rot_unit (
    .instr(instr), .rs1Val(rs1Val), .rs2Val(rs2Val), .extEnable(extEnable),
    .result(result), .hit(hit), .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
                                      input logic [2:0] f3, input logic [6:0] op);
    return {f7, r2, 5'd7, f3, 5'd9, op};
  endfunction

  function automatic logic [63:0] rr64(input logic [63:0] x, input int n);
    n = n % 64;
    return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
  endfunction
  function automatic logic [63:0] rl64(input logic [63:0] x, input int n);
    n = n % 64;
    return (n == 0) ? x : ((x << n) | (x >> (64 - n)));
  endfunction
  function automatic logic [63:0] rw(input logic [63:0] x, input int n, input bit left);
    logic [31:0] v;
    logic [31:0] r;
    v = x[31:0];
    n = n % 32;
    if (n == 0) r = v;
    else if (left) r = (v << n) | (v >> (32 - n));
    else r = (v >> n) | (v << (32 - n));
    return {{32{r[31]}}, r};
  endfunction

  task automatic drive(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b,
                       input logic en);
    @(negedge clk);
    instr = i; rs1Val = a; rs2Val = b; extEnable = en;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_idle();
    drive(32'h0000_0013, 64'hFFFF, 64'h3, 1'b1);
    check("R11 idle hit", {63'd0, hit}, 64'd0);
    check("R11 idle result", result, 64'd0);
    check("R11 idle illegal", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_ror_rol();
    for (int n = 0; n < 64; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0110011), a, 64'(n), 1'b1);
      check("R1 ror", result, rr64(a, n));
      check("R1 ror hit", {63'd0, hit}, 64'd1);
      drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0110011), a, 64'(n), 1'b1);
      check("R2 rol", result, rl64(a, n));
    end
  endtask

  task automatic t_rori();
    for (int n = 0; n < 64; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      drive(enc({6'b011000, 1'(n >> 5)}, 5'(n), 3'b101, 7'b0010011), a,
            64'hDEAD_BEEF_0000_0011, 1'b1);
      check("R3 rori", result, rr64(a, n));
    end
  endtask

  task automatic t_word();
    for (int n = 0; n < 32; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0111011), a, 64'(n), 1'b1);
      check("R4 rorw", result, rw(a, n, 1'b0));
      drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0111011), a, 64'(n), 1'b1);
      check("R4 rolw", result, rw(a, n, 1'b1));
      drive(enc(7'b0110000, 5'(n), 3'b101, 7'b0011011), a, 64'h1F, 1'b1);
      check("R5 roriw", result, rw(a, n, 1'b0));
    end
    drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0111011), 64'h0000_0000_0000_0001, 64'd1, 1'b1);
    check("R4 sext rorw", result, 64'hFFFF_FFFF_8000_0000);
  endtask

  task automatic t_no_imm_left();
    drive(enc(7'b0110000, 5'd3, 3'b001, 7'b0010011), 64'h1234, 64'd3, 1'b1);
    check("R6 imm rol hit", {62'd0, hit, illegal}, 64'd0);
    check("R6 imm rol result", result, 64'd0);
    drive(enc(7'b0110000, 5'd3, 3'b001, 7'b0011011), 64'h1234, 64'd3, 1'b0);
    check("R6 imm rolw flags", {62'd0, hit, illegal}, 64'd0);
  endtask

  task automatic t_disabled();
    logic [31:0] encs [6];
    encs[0] = enc(7'b0110000, 5'd2, 3'b101, 7'b0110011);
    encs[1] = enc(7'b0110000, 5'd2, 3'b001, 7'b0110011);
    encs[2] = enc(7'b0110000, 5'd5, 3'b101, 7'b0010011);
    encs[3] = enc(7'b0110000, 5'd2, 3'b101, 7'b0111011);
    encs[4] = enc(7'b0110000, 5'd2, 3'b001, 7'b0111011);
    encs[5] = enc(7'b0110000, 5'd5, 3'b101, 7'b0011011);
    for (int k = 0; k < 6; k++) begin
      drive(encs[k], 64'h0123_4567_89AB_CDEF, 64'd4, 1'b0);
      check("R7 disabled flags", {62'd0, hit, illegal}, 64'd1);
      check("R7 disabled result", result, 64'd0);
      drive(encs[k], 64'h0123_4567_89AB_CDEF, 64'd4, 1'b1);
      check("R7 enabled flags", {62'd0, hit, illegal}, 64'd2);
    end
  endtask

  task automatic t_high_bits();
    logic [63:0] a;
    a = 64'hF0E1_D2C3_B4A5_9687;
    drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0110011), a, 64'hFFFF_FFFF_FFFF_FFC5, 1'b1);
    check("R8 ror high bits", result, rr64(a, 5));
    drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0111011), a, 64'h0000_0000_0000_0027, 1'b1);
    check("R8 rolw bit5 ignored", result, rw(a, 7, 1'b1));
  endtask

  task automatic t_zero_amt();
    drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0110011), 64'h8000_0000_0000_0001, 64'd64, 1'b1);
    check("R9 rol zero", result, 64'h8000_0000_0000_0001);
    drive(enc(7'b0110000, 5'd0, 3'b101, 7'b0011011), 64'h1234_5678_9000_0000, 64'd0, 1'b1);
    check("R9 roriw zero", result, 64'hFFFF_FFFF_9000_0000);
  endtask

  task automatic t_identity();
    for (int n = 0; n < 64; n++) begin
      logic [63:0] a;
      logic [63:0] lv;
      a = {$urandom, $urandom};
      drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0110011), a, 64'(n), 1'b1);
      lv = result;
      drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0110011), a, 64'((64 - n) % 64), 1'b1);
      check("R10 rol/ror 64", lv, result);
      if (n < 32) begin
        drive(enc(7'b0110000, 5'd2, 3'b001, 7'b0111011), a, 64'(n), 1'b1);
        lv = result;
        drive(enc(7'b0110000, 5'd2, 3'b101, 7'b0111011), a, 64'((32 - n) % 32), 1'b1);
        check("R10 rolw/rorw", lv, result);
      end
    end
  endtask

  task automatic t_non_rotate();
    drive(enc(7'b0000000, 5'd2, 3'b000, 7'b0110011), 64'h55, 64'h1, 1'b1);
    check("R11 add result", result, 64'd0);
    check("R11 add flags", {62'd0, hit, illegal}, 64'd0);
    drive(enc(7'b0010000, 5'd2, 3'b101, 7'b0110011), 64'h55, 64'h1, 1'b0);
    check("R11 other funct7 flags", {62'd0, hit, illegal}, 64'd0);
    drive(enc(7'b0110001, 5'd2, 3'b101, 7'b0011011), 64'h55, 64'h1, 1'b1);
    check("R11 roriw bad bit25", {62'd0, hit, illegal}, 64'd0);
  endtask

  initial begin
    #20 rstN = 1'b1;
    t_idle();
    t_ror_rol();
    t_rori();
    t_word();
    t_no_imm_left();
    t_disabled();
    t_high_bits();
    t_zero_amt();
    t_identity();
    t_non_rotate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule